// File: doc/BRIEF.md
# ATM Cell Boundary Hunter

This block finds where ATM cells begin inside a byte stream recovered from a transmission payload. It takes one byte per clock, qualified by a valid strobe. For every byte it computes a CRC-8 over the four bytes before it and checks whether the byte equals that header check value. While no alignment is known, every byte is a candidate, so the search slips forward one byte at a time. After a first hit it looks only at positions exactly one cell (53 bytes) apart. It declares alignment after seven hits in a row. Once aligned it watches every header and drops back to searching after seven bad headers in a row.

Downstream logic uses the cell-start pulse and the byte index to split the stream into headers and payloads. The alignment-loss alarm tells it when that framing cannot be trusted. Carrier framing, header error correction and payload descrambling belong to neighbouring blocks.

Top module: `atm_cell_delineator`

## Requirements
- R1: After reset `lca_alarm` is 1, `cell_start` is 0 and `byte_idx` is 0, and the block is searching.
- R2: A byte is a header match when it equals C XOR 0x55. C is the CRC-8 (generator x^8+x^2+x+1, i.e. 0x07, initial value 0, most significant bit first) of the four valid bytes received just before it, oldest first. Bytes not yet received since reset count as 0x00.
- R3: While searching, every valid byte is tested, so a failed candidate moves the search forward by exactly one byte.
- R4: After a first match, only the byte 53 valid bytes later is tested. The seventh consecutive such match brings `lca_alarm` to 0 from the next byte on.
- R5: A failed header test before alignment is declared returns the block to searching. The match count restarts from zero, so seven fresh matches are needed again.
- R6: While aligned, seven consecutive mismatching cell headers raise `lca_alarm` from the next byte on and restart the search.
- R7: While aligned, one matching header clears the count of consecutive mismatches.
- R8: `cell_start` is 1 exactly when `in_valid` is 1, the block is aligned and the current byte is byte 0 of a cell.
- R9: Outside the search, `byte_idx` gives the position (0..52) of the current byte within its cell. The byte after a match has index 5, and the count wraps from 52 to 0. While searching, `byte_idx` is 0.
- R10: A cycle with `in_valid` at 0 changes no state and gives no `cell_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_byte` |
| in_byte | input | 8 | Stream byte |
| cell_start | output | 1 | First byte of a cell, only while aligned |
| byte_idx | output | 6 | Position of the current byte within the cell |
| lca_alarm | output | 1 | Cell alignment not established |

## Verification
The hardest situation to reach is a mismatch count that reaches six, either in the pre-lock phase or in the aligned phase, followed by the one header that decides the outcome. Random payload alone almost never produces it. The bench builds cells with correct or deliberately corrupted check bytes in chosen sequences: six good then one bad before lock, six bad then a good one while aligned, and then seven bad. A byte-level reference model follows along, and a sweep of all 53 starting offsets with random garbage ahead of the cells covers false matches during the search.

// File: rtl/atm_dlin_pkg.sv
package atm_dlin_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PRE  = 2'd1,
        ST_SYNC = 2'd2
    } dlin_state_e;

endpackage

// File: rtl/atm_hdr_window.sv
module atm_hdr_window #(
    parameter int          HDR_LEN   = 5,
    parameter logic [7:0]  HEC_POLY  = 8'h07,
    parameter logic [7:0]  HEC_COSET = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       hec_ok
);
    localparam int WIN_BITS = (HDR_LEN - 1) * 8;

    typedef struct packed {
        logic [WIN_BITS-1:0] win;
    } win_regs_t;

    win_regs_t r_q, r_d;
    logic [7:0] rem;

    // shift the last HDR_LEN-1 valid bytes, newest in the low byte
    always_comb begin
        r_d = r_q;
        if (in_valid) begin
            r_d.win = {r_q.win[WIN_BITS-9:0], in_byte};
        end
    end

    // CRC remainder of the window, bit-serial, MSB first
    always_comb begin
        rem = 8'h00;
        for (int i = WIN_BITS - 1; i >= 0; i--) begin
            rem = {rem[6:0], 1'b0} ^ ((rem[7] ^ r_q.win[i]) ? HEC_POLY : 8'h00);
        end
        hec_ok = ((rem ^ HEC_COSET) == in_byte);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/atm_delin_fsm.sv
module atm_delin_fsm
    import atm_dlin_pkg::*;
#(
    parameter int CELL_LEN = 53,
    parameter int HDR_LEN  = 5,
    parameter int LOCK_CNT = 7,
    parameter int LOSE_CNT = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        hec_ok,
    output logic                        cell_start,
    output logic [$clog2(CELL_LEN)-1:0] byte_idx,
    output logic                        lca_alarm
);
    localparam int IDX_W  = $clog2(CELL_LEN);
    localparam int CNT_MX = (LOCK_CNT > LOSE_CNT) ? LOCK_CNT : LOSE_CNT;
    localparam int CNT_W  = $clog2(CNT_MX + 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CELL_LEN - 1);
    localparam logic [IDX_W-1:0] HEC_IDX   = IDX_W'(HDR_LEN - 1);
    localparam logic [IDX_W-1:0] AFTER_HDR = IDX_W'(HDR_LEN);
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CNT - 1);
    localparam logic [CNT_W-1:0] LOSE_LAST = CNT_W'(LOSE_CNT - 1);

    typedef struct packed {
        dlin_state_e      state;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } fsm_regs_t;

    localparam fsm_regs_t RST_VAL = '{state: ST_HUNT, idx: '0, cnt: '0};

    fsm_regs_t r_q, r_d;
    logic [IDX_W-1:0] idx_inc;

    always_comb begin
        r_d     = r_q;
        idx_inc = (r_q.idx == LAST_IDX) ? '0 : r_q.idx + IDX_W'(1);
        if (in_valid) begin
            unique case (r_q.state)
                ST_HUNT: begin
                    if (hec_ok) begin
                        r_d.idx = AFTER_HDR;
                        if (LOCK_CNT <= 1) begin
                            r_d.state = ST_SYNC;
                            r_d.cnt   = '0;
                        end else begin
                            r_d.state = ST_PRE;
                            r_d.cnt   = CNT_W'(1);
                        end
                    end
                end
                ST_PRE: begin
                    r_d.idx = idx_inc;
                    if (r_q.idx == HEC_IDX) begin
                        if (!hec_ok) begin
                            r_d = RST_VAL;
                        end else if (r_q.cnt == LOCK_LAST) begin
                            r_d.state = ST_SYNC;
                            r_d.cnt   = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_SYNC: begin
                    r_d.idx = idx_inc;
                    if (r_q.idx == HEC_IDX) begin
                        if (hec_ok) begin
                            r_d.cnt = '0;
                        end else if (r_q.cnt == LOSE_LAST) begin
                            r_d = RST_VAL;
                        end else begin
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                        end
                    end
                end
                default: r_d = RST_VAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign cell_start = in_valid && (r_q.state == ST_SYNC) && (r_q.idx == '0);
    assign byte_idx   = r_q.idx;
    assign lca_alarm  = (r_q.state != ST_SYNC);

endmodule

// File: rtl/atm_cell_delineator.sv
module atm_cell_delineator #(
    parameter int         CELL_LEN  = 53,
    parameter int         HDR_LEN   = 5,
    parameter int         LOCK_CNT  = 7,
    parameter int         LOSE_CNT  = 7,
    parameter logic [7:0] HEC_POLY  = 8'h07,
    parameter logic [7:0] HEC_COSET = 8'h55
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [7:0]                  in_byte,
    output logic                        cell_start,
    output logic [$clog2(CELL_LEN)-1:0] byte_idx,
    output logic                        lca_alarm
);
    logic hec_ok;

    atm_hdr_window #(
        .HDR_LEN  (HDR_LEN),
        .HEC_POLY (HEC_POLY),
        .HEC_COSET(HEC_COSET)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_byte (in_byte),
        .hec_ok  (hec_ok)
    );

    atm_delin_fsm #(
        .CELL_LEN(CELL_LEN),
        .HDR_LEN (HDR_LEN),
        .LOCK_CNT(LOCK_CNT),
        .LOSE_CNT(LOSE_CNT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .hec_ok    (hec_ok),
        .cell_start(cell_start),
        .byte_idx  (byte_idx),
        .lca_alarm (lca_alarm)
    );

endmodule

// File: rtl/atm_cell_delineator_chk.sv
module atm_cell_delineator_chk #(
    parameter int CELL_LEN = 53,
    parameter int HDR_LEN  = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        hec_ok,
    input logic                        cell_start,
    input logic [$clog2(CELL_LEN)-1:0] byte_idx,
    input logic                        lca_alarm
);
    localparam int IDX_W = $clog2(CELL_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_LEN - 1);
    localparam logic [IDX_W-1:0] HEC_IDX  = IDX_W'(HDR_LEN - 1);

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cell_start |-> (in_valid && !lca_alarm && byte_idx == '0)); // R8

    AST_IDX_IN_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        byte_idx <= LAST_IDX); // R9

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lca_alarm && byte_idx != HEC_IDX && byte_idx != LAST_IDX)
        |=> (byte_idx == $past(byte_idx) + IDX_W'(1))); // R9

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(byte_idx) && $stable(lca_alarm))); // R10

    AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !cell_start); // R10

    AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lca_alarm) |-> ($past(hec_ok) && $past(in_valid) && $past(byte_idx) == HEC_IDX)); // R4

    AST_LOSS_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lca_alarm) |-> (!$past(hec_ok) && $past(in_valid) && $past(byte_idx) == HEC_IDX)); // R6

endmodule

bind atm_cell_delineator atm_cell_delineator_chk #(
    .CELL_LEN(CELL_LEN),
    .HDR_LEN (HDR_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .hec_ok    (hec_ok),
    .cell_start(cell_start),
    .byte_idx  (byte_idx),
    .lca_alarm (lca_alarm)
);

// File: tb/atm_cell_delineator_test.sv
module atm_cell_delineator_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       cell_start;
    logic [5:0] byte_idx;
    logic       lca_alarm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    int        m_state;   // 0 search, 1 pre-lock, 2 aligned
    int        m_cnt;
    int        m_idx;
    logic [7:0] m_hist [4];

    always #2 clk = ~clk;

    atm_cell_delineator uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .cell_start(cell_start),
        .byte_idx  (byte_idx),
        .lca_alarm (lca_alarm)
    );

    function automatic logic [7:0] tb_hec(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [7:0] b2, input logic [7:0] b3);
        logic [7:0] c;
        logic [7:0] bs [4];
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
        c = 8'h00;
        for (int k = 0; k < 4; k++) begin
            c = c ^ bs[k];
            for (int j = 0; j < 8; j++) begin
                c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
            end
        end
        return c ^ 8'h55;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_cnt = 0; m_idx = 0;
        for (int k = 0; k < 4; k++) m_hist[k] = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic model_step(input logic [7:0] b);
        bit hit;
        int nidx;
        hit  = (b == tb_hec(m_hist[0], m_hist[1], m_hist[2], m_hist[3]));
        nidx = (m_idx == 52) ? 0 : m_idx + 1;
        case (m_state)
            0: if (hit) begin m_state = 1; m_cnt = 1; m_idx = 5; end
            1: begin
                m_idx = nidx;
                if (nidx == 5) begin
                    if (!hit) begin m_state = 0; m_cnt = 0; m_idx = 0; end
                    else if (m_cnt == 6) begin m_state = 2; m_cnt = 0; end
                    else m_cnt++;
                end
            end
            default: begin
                m_idx = nidx;
                if (nidx == 5) begin
                    if (hit) m_cnt = 0;
                    else if (m_cnt == 6) begin m_state = 0; m_cnt = 0; m_idx = 0; end
                    else m_cnt++;
                end
            end
        endcase
        m_hist[0] = m_hist[1]; m_hist[1] = m_hist[2]; m_hist[2] = m_hist[3]; m_hist[3] = b;
    endtask

    // drive one byte, compare outputs for that byte, advance the model
    task automatic send(input logic [7:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b;
        #1;
        chk({tag, " R4 R6 alarm"}, lca_alarm, (m_state != 2));
        chk({tag, " R8 start"}, cell_start, (m_state == 2 && m_idx == 0));
        chk({tag, " R9 idx"}, byte_idx, m_idx);
        model_step(b);
    endtask

    task automatic gap(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_byte = $urandom();
            #1;
            chk({tag, " R10 start"}, cell_start, 0);
            chk({tag, " R10 alarm"}, lca_alarm, (m_state != 2));
            chk({tag, " R10 idx"}, byte_idx, m_idx);
        end
    endtask

    task automatic send_cell(input bit good, input int gaps, input string tag);
        logic [7:0] h [4];
        logic [7:0] hec;
        for (int k = 0; k < 4; k++) h[k] = $urandom();
        hec = tb_hec(h[0], h[1], h[2], h[3]);
        if (!good) hec = hec ^ 8'h01;
        for (int k = 0; k < 4; k++) begin
            send(h[k], tag);
            if (gaps > 0) gap($urandom_range(0, gaps), tag);
        end
        send(hec, tag);
        for (int k = 0; k < 48; k++) begin
            send($urandom(), tag);
            if (gaps > 0) gap($urandom_range(0, gaps), tag);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 alarm", lca_alarm, 1);
        chk("R1 start", cell_start, 0);
        chk("R1 idx", byte_idx, 0);

        // every starting offset, garbage ahead of good cells
        for (int off = 0; off < 53; off++) begin
            do_reset();
            for (int k = 0; k < off; k++) send($urandom(), "R2 R3 prefix");
            for (int c = 0; c < 9; c++) send_cell(1'b1, 0, "R2 R3 R4 lock");
            chk("R4 locked after sweep", lca_alarm, 0);
        end

        // six good then one bad before lock: relock needs seven fresh
        do_reset();
        for (int c = 0; c < 6; c++) send_cell(1'b1, 0, "R5 pre");
        send_cell(1'b0, 0, "R5 miss");
        for (int c = 0; c < 6; c++) send_cell(1'b1, 0, "R5 relock");
        for (int c = 0; c < 3; c++) send_cell(1'b1, 0, "R5 relock");

        // aligned: six bad then a good one, repeated, then seven bad
        for (int c = 0; c < 6; c++) send_cell(1'b0, 0, "R7 bad");
        send_cell(1'b1, 0, "R7 clear");
        for (int c = 0; c < 6; c++) send_cell(1'b0, 0, "R7 bad");
        send_cell(1'b1, 0, "R7 clear");
        chk("R7 still aligned", lca_alarm, 0);
        for (int c = 0; c < 7; c++) send_cell(1'b0, 0, "R6 lose");
        for (int c = 0; c < 2; c++) send_cell(1'b1, 0, "R6 hunt");

        // stream with idle cycles between bytes
        do_reset();
        for (int c = 0; c < 12; c++) send_cell(1'b1, 2, "R10 gaps");
        chk("R10 locked with gaps", lca_alarm, 0);
        for (int c = 0; c < 8; c++) send_cell(1'b0, 1, "R10 gaps bad");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule